// File: doc/BRIEF.md
# Configuration Cycle Router for a Bus Bridge

This block sits behind the primary-side target of a bus-to-bus bridge. It looks at every configuration access that arrives there and picks one outcome. The bridge may answer the access from its own register file. It may pass the access on to the secondary side unchanged, as a type 1 access. It may rewrite it into a type 0 access that a device on the secondary bus recognises. It may raise a master abort. Or it may let the access go by with no response.

Each request is accepted through a valid/ready handshake, and the decision is registered. A local claim and a master abort each appear as a single-cycle strobe in the cycle after acceptance. A forward request is held, together with its rewritten address, type and command, until the secondary-side master takes it. While a forward is waiting, no new request is accepted. The three bus-number registers (primary, secondary, subordinate) are static inputs.

Top module: `cfgx_router`

## Requirements
- R1: A request with a configuration command (read 4'b1010, write 4'b1011), `in_type1`=0 and `in_idsel`=1 produces a one-cycle `loc_claim` in the cycle after acceptance. At the same time `loc_func` carries address bits 10:8, `loc_reg` carries bits 7:2, and nothing is forwarded.
- R2: A type 0 configuration request with `in_idsel`=0 produces no claim, no forward and no abort.
- R3: A type 1 configuration request whose bus field (address bits 23:16) equals `sec_bus`, with a device field d (bits 15:11) of 0 to 15, is forwarded with `fwd_type1`=0. The forwarded address has only bit 16+d set in bits 31:16, zeros in bits 15:11, the function and register fields copied into bits 10:2, and bits 1:0 equal to 00.
- R4: A type 1 configuration request to the secondary bus with a device field above 15 produces a one-cycle `mabort` and no forward.
- R5: A type 1 configuration request whose bus field is greater than `sec_bus` and not greater than `sub_bus` is forwarded with `fwd_type1`=1 and the address unchanged.
- R6: A type 1 configuration request whose bus field is below `sec_bus`, above `sub_bus`, or equal to `pri_bus` produces no claim, no forward and no abort.
- R7: A request whose command is not a configuration command produces no claim, no forward and no abort.
- R8: While `fwd_valid` is high and `fwd_ready` is low, `fwd_valid`, `fwd_addr` and `fwd_type1` hold, and `in_ready` is low, so no request is accepted.
- R9: After reset, `loc_claim`, `mabort` and `fwd_valid` are low and `in_ready` is high.
- R10: `out_cmd` carries the command of the accepted request whenever `loc_claim` or `fwd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_bus | input | 8 | Primary bus number register |
| sec_bus | input | 8 | Secondary bus number register |
| sub_bus | input | 8 | Subordinate bus number register |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | 32 | Configuration address |
| in_type1 | input | 1 | 1 = type 1 access, 0 = type 0 access |
| in_cmd | input | 4 | Bus command |
| in_idsel | input | 1 | Device select hit for a type 0 access |
| loc_claim | output | 1 | One-cycle strobe: access is answered locally |
| loc_func | output | 3 | Function number of the local access |
| loc_reg | output | 6 | Dword register index of the local access |
| out_cmd | output | 4 | Command of the claimed or forwarded access |
| fwd_valid | output | 1 | Forward request for the secondary side |
| fwd_ready | input | 1 | Secondary master takes the forward request |
| fwd_addr | output | 32 | Address to drive on the secondary side |
| fwd_type1 | output | 1 | Type of the forwarded access |
| mabort | output | 1 | One-cycle strobe: master abort |

## Verification
The bench builds the router with its defaults: a 32-bit address, an 8-bit bus field, a 5-bit device field and the one-hot device select starting at bit 16. This brings every one of the 16 one-hot positions within reach, along with devices 16 to 31, which fall through to a master abort. With the secondary bus at 1 and the subordinate bus at 4, the bench covers both range edges (buses 1 and 4) and the buses just outside them (0 and 5). A separate run sets the primary bus number to 2, inside the forward range, to show that the primary match takes precedence.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [2:0] {
        RT_NONE  = 3'd0,
        RT_LOCAL = 3'd1,
        RT_FWD1  = 3'd2,
        RT_FWD0  = 3'd3,
        RT_ABORT = 3'd4
    } route_e;

    localparam logic [2:0] CMD_CFG_MSBS = 3'b101;

endpackage

// File: rtl/cfgx_classify.sv
module cfgx_classify
    import cfgx_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int DEV_W   = 5,
    parameter int IDSEL_N = 16
) (
    input  logic [BUS_W-1:0] pri_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    input  logic [BUS_W-1:0] tgt_bus,
    input  logic [DEV_W-1:0] tgt_dev,
    input  logic             is_type1,
    input  logic [3:0]       cmd,
    input  logic             idsel,
    output route_e           route
);

    logic is_cfg;
    logic dev_ok;
    logic deeper;

    always_comb begin
        is_cfg = (cmd[3:1] == CMD_CFG_MSBS);
        dev_ok = (int'(tgt_dev) < IDSEL_N);
        deeper = (tgt_bus > sec_bus) && (tgt_bus <= sub_bus);
        route  = RT_NONE;
        if (is_cfg) begin
            if (!is_type1) begin
                if (idsel) route = RT_LOCAL;
            end else if (tgt_bus == pri_bus) begin
                route = RT_NONE;
            end else if (tgt_bus == sec_bus) begin
                route = dev_ok ? RT_FWD0 : RT_ABORT;
            end else if (deeper) begin
                route = RT_FWD1;
            end
        end
    end

endmodule

// File: rtl/cfgx_retarget.sv
module cfgx_retarget #(
    parameter int ADDR_W   = 32,
    parameter int DEV_W    = 5,
    parameter int FN_W     = 3,
    parameter int REG_W    = 6,
    parameter int IDSEL_LO = 16,
    parameter int REG_LO   = 2
) (
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    input  logic [REG_W-1:0]  rg,
    output logic [ADDR_W-1:0] addr0
);

    localparam int IDSEL_N = ADDR_W - IDSEL_LO;
    localparam int FN_LO   = REG_LO + REG_W;

    logic [IDSEL_N-1:0] sel;

    for (genvar g = 0; g < IDSEL_N; g++) begin : g_sel
        assign sel[g] = (int'(dev) == g);
    end

    always_comb begin
        addr0                      = '0;
        addr0[IDSEL_LO +: IDSEL_N] = sel;
        addr0[FN_LO +: FN_W]       = fn;
        addr0[REG_LO +: REG_W]     = rg;
    end

endmodule

// File: rtl/cfgx_router.sv
module cfgx_router
    import cfgx_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BUS_W    = 8,
    parameter int DEV_W    = 5,
    parameter int FN_W     = 3,
    parameter int REG_W    = 6,
    parameter int IDSEL_LO = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  pri_bus,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_type1,
    input  logic [3:0]        in_cmd,
    input  logic              in_idsel,
    output logic              loc_claim,
    output logic [FN_W-1:0]   loc_func,
    output logic [REG_W-1:0]  loc_reg,
    output logic [3:0]        out_cmd,
    output logic              fwd_valid,
    input  logic              fwd_ready,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_type1,
    output logic              mabort
);

    localparam int REG_LO  = 2;
    localparam int FN_LO   = REG_LO + REG_W;
    localparam int DEV_LO  = FN_LO + FN_W;
    localparam int BUS_LO  = DEV_LO + DEV_W;
    localparam int IDSEL_N = ADDR_W - IDSEL_LO;

    typedef struct packed {
        logic              fwd_v;
        logic [ADDR_W-1:0] fwd_a;
        logic              fwd_t1;
        logic              loc;
        logic              abt;
        logic [FN_W-1:0]   fn;
        logic [REG_W-1:0]  rg;
        logic [3:0]        cmd;
    } st_t;

    st_t st_d, st_q;

    route_e            route;
    logic [ADDR_W-1:0] addr0;
    logic              accept;

    cfgx_classify #(
        .BUS_W   (BUS_W),
        .DEV_W   (DEV_W),
        .IDSEL_N (IDSEL_N)
    ) u_classify (
        .pri_bus  (pri_bus),
        .sec_bus  (sec_bus),
        .sub_bus  (sub_bus),
        .tgt_bus  (in_addr[BUS_LO +: BUS_W]),
        .tgt_dev  (in_addr[DEV_LO +: DEV_W]),
        .is_type1 (in_type1),
        .cmd      (in_cmd),
        .idsel    (in_idsel),
        .route    (route)
    );

    cfgx_retarget #(
        .ADDR_W   (ADDR_W),
        .DEV_W    (DEV_W),
        .FN_W     (FN_W),
        .REG_W    (REG_W),
        .IDSEL_LO (IDSEL_LO),
        .REG_LO   (REG_LO)
    ) u_retarget (
        .dev   (in_addr[DEV_LO +: DEV_W]),
        .fn    (in_addr[FN_LO +: FN_W]),
        .rg    (in_addr[REG_LO +: REG_W]),
        .addr0 (addr0)
    );

    assign in_ready = !st_q.fwd_v;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d     = st_q;
        st_d.loc = 1'b0;
        st_d.abt = 1'b0;
        if (st_q.fwd_v && fwd_ready) st_d.fwd_v = 1'b0;
        if (accept) begin
            st_d.cmd = in_cmd;
            case (route)
                RT_LOCAL: begin
                    st_d.loc = 1'b1;
                    st_d.fn  = in_addr[FN_LO +: FN_W];
                    st_d.rg  = in_addr[REG_LO +: REG_W];
                end
                RT_FWD1: begin
                    st_d.fwd_v  = 1'b1;
                    st_d.fwd_a  = in_addr;
                    st_d.fwd_t1 = 1'b1;
                end
                RT_FWD0: begin
                    st_d.fwd_v  = 1'b1;
                    st_d.fwd_a  = addr0;
                    st_d.fwd_t1 = 1'b0;
                end
                RT_ABORT: st_d.abt = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign loc_claim = st_q.loc;
    assign loc_func  = st_q.fn;
    assign loc_reg   = st_q.rg;
    assign out_cmd   = st_q.cmd;
    assign fwd_valid = st_q.fwd_v;
    assign fwd_addr  = st_q.fwd_a;
    assign fwd_type1 = st_q.fwd_t1;
    assign mabort    = st_q.abt;

endmodule

// File: rtl/cfgx_router_chk.sv
module cfgx_router_chk #(
    parameter int ADDR_W   = 32,
    parameter int IDSEL_LO = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_type1,
    input logic              in_idsel,
    input logic              loc_claim,
    input logic              fwd_valid,
    input logic              fwd_ready,
    input logic [ADDR_W-1:0] fwd_addr,
    input logic              fwd_type1,
    input logic              mabort
);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_type1));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !in_ready);

    p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_claim, mabort, fwd_valid}));

    p_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid && !fwd_type1 |->
            ($countones(fwd_addr[ADDR_W-1:IDSEL_LO]) == 1) && (fwd_addr[1:0] == 2'b00));

    p_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
        loc_claim |-> $past(in_valid && in_ready && !in_type1 && in_idsel));

    p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        loc_claim |=> !loc_claim);

endmodule

bind cfgx_router cfgx_router_chk #(
    .ADDR_W   (ADDR_W),
    .IDSEL_LO (IDSEL_LO)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_type1  (in_type1),
    .in_idsel  (in_idsel),
    .loc_claim (loc_claim),
    .fwd_valid (fwd_valid),
    .fwd_ready (fwd_ready),
    .fwd_addr  (fwd_addr),
    .fwd_type1 (fwd_type1),
    .mabort    (mabort)
);

// File: tb/sim_cfgx_router.sv
`timescale 1ns/1ps
module sim_cfgx_router;

    typedef struct packed {
        logic [31:0] addr;
        logic        t1;
        logic [3:0]  cmd;
        logic        idsel;
        logic [2:0]  exp;   // 0 none, 1 local, 2 fwd type1, 3 fwd type0, 4 abort
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{{16'h0000, 5'd0, 3'd2, 6'd9, 2'b00},  1'b0, 4'b1010, 1'b1, 3'd1},
        '{{16'h0000, 5'd0, 3'd1, 6'd3, 2'b00},  1'b0, 4'b1010, 1'b0, 3'd0},
        '{{16'h0001, 5'd3, 3'd2, 6'd5, 2'b01},  1'b1, 4'b1010, 1'b0, 3'd3},
        '{{16'h0001, 5'd15, 3'd7, 6'd63, 2'b01}, 1'b1, 4'b1011, 1'b0, 3'd3},
        '{{16'h0001, 5'd0, 3'd0, 6'd1, 2'b01},  1'b1, 4'b1011, 1'b0, 3'd3},
        '{{16'h0001, 5'd16, 3'd0, 6'd0, 2'b01}, 1'b1, 4'b1010, 1'b0, 3'd4},
        '{{16'h0001, 5'd31, 3'd1, 6'd2, 2'b01}, 1'b1, 4'b1010, 1'b0, 3'd4},
        '{{16'h0002, 5'd20, 3'd4, 6'd7, 2'b01}, 1'b1, 4'b1010, 1'b0, 3'd2},
        '{{16'hA504, 5'd9, 3'd3, 6'd8, 2'b01},  1'b1, 4'b1011, 1'b0, 3'd2},
        '{{16'h0005, 5'd1, 3'd0, 6'd0, 2'b01},  1'b1, 4'b1010, 1'b0, 3'd0},
        '{{16'h0000, 5'd2, 3'd0, 6'd0, 2'b01},  1'b1, 4'b1010, 1'b0, 3'd0},
        '{{16'h0001, 5'd3, 3'd0, 6'd0, 2'b01},  1'b1, 4'b0110, 1'b0, 3'd0},
        '{{16'h0000, 5'd0, 3'd0, 6'd4, 2'b00},  1'b0, 4'b0010, 1'b1, 3'd0},
        '{{16'h0003, 5'd6, 3'd5, 6'd11, 2'b01}, 1'b1, 4'b1011, 1'b0, 3'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pri_bus = 8'd0, sec_bus = 8'd1, sub_bus = 8'd4;
    logic        in_valid = 1'b0, in_type1 = 1'b0, in_idsel = 1'b0, fwd_ready = 1'b1;
    logic [31:0] in_addr = '0;
    logic [3:0]  in_cmd = '0;
    logic        in_ready, loc_claim, fwd_valid, fwd_type1, mabort;
    logic [2:0]  loc_func;
    logic [5:0]  loc_reg;
    logic [3:0]  out_cmd;
    logic [31:0] fwd_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfgx_router u0 (
        .clk(clk), .rst_n(rst_n), .pri_bus(pri_bus), .sec_bus(sec_bus), .sub_bus(sub_bus),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_type1(in_type1),
        .in_cmd(in_cmd), .in_idsel(in_idsel), .loc_claim(loc_claim), .loc_func(loc_func),
        .loc_reg(loc_reg), .out_cmd(out_cmd), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
        .fwd_addr(fwd_addr), .fwd_type1(fwd_type1), .mabort(mabort)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.cmd[3:1] != 3'b101) return "R7";
        case (v.exp)
            3'd1: return "R1";
            3'd2: return "R5";
            3'd3: return "R3";
            3'd4: return "R4";
            default: return v.t1 ? "R6" : "R2";
        endcase
    endfunction

    function automatic logic [31:0] type0_of(input logic [31:0] a);
        logic [31:0] r;
        r = 32'h1 << (16 + int'(a[15:11]));
        r[10:8] = a[10:8];
        r[7:2]  = a[7:2];
        return r;
    endfunction

    task automatic apply(input vec_t v);
        @(negedge clk);
        in_addr = v.addr; in_type1 = v.t1; in_cmd = v.cmd; in_idsel = v.idsel; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 loc_claim", 32'(loc_claim), 0);
        chk("R9 mabort", 32'(mabort), 0);
        chk("R9 fwd_valid", 32'(fwd_valid), 0);
        chk("R9 in_ready", 32'(in_ready), 1);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = tag_of(VECS[i]);
            apply(VECS[i]);
            chk(t, 32'(loc_claim), 32'(VECS[i].exp == 3'd1));
            chk(t, 32'(mabort), 32'(VECS[i].exp == 3'd4));
            chk(t, 32'(fwd_valid), 32'(VECS[i].exp == 3'd2 || VECS[i].exp == 3'd3));
            if (VECS[i].exp == 3'd1) begin
                chk("R1 func", 32'(loc_func), 32'(VECS[i].addr[10:8]));
                chk("R1 reg", 32'(loc_reg), 32'(VECS[i].addr[7:2]));
                chk("R10 cmd", 32'(out_cmd), 32'(VECS[i].cmd));
            end
            if (VECS[i].exp == 3'd2) begin
                chk("R5 type", 32'(fwd_type1), 1);
                chk("R5 addr", fwd_addr, VECS[i].addr);
                chk("R10 cmd", 32'(out_cmd), 32'(VECS[i].cmd));
            end
            if (VECS[i].exp == 3'd3) begin
                chk("R3 type", 32'(fwd_type1), 0);
                chk("R3 addr", fwd_addr, type0_of(VECS[i].addr));
                chk("R10 cmd", 32'(out_cmd), 32'(VECS[i].cmd));
            end
            @(negedge clk);
            chk("R1 one-cycle strobes", 32'({loc_claim, mabort, fwd_valid}), 0);
        end

        // R6: primary bus match wins over the forward range
        pri_bus = 8'd2;
        apply(VECS[7]);
        chk("R6 pri match fwd", 32'(fwd_valid), 0);
        chk("R6 pri match claim", 32'({loc_claim, mabort}), 0);
        pri_bus = 8'd0;
        @(negedge clk);

        // R8: backpressure holds forward and blocks new requests
        fwd_ready = 1'b0;
        apply(VECS[2]);
        chk("R8 fwd_valid", 32'(fwd_valid), 1);
        chk("R8 in_ready", 32'(in_ready), 0);
        in_addr = VECS[0].addr; in_type1 = VECS[0].t1; in_cmd = VECS[0].cmd;
        in_idsel = VECS[0].idsel; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 held valid", 32'(fwd_valid), 1);
        chk("R8 held addr", fwd_addr, type0_of(VECS[2].addr));
        chk("R8 held type", 32'(fwd_type1), 0);
        chk("R8 blocked claim", 32'(loc_claim), 0);
        fwd_ready = 1'b1;
        @(negedge clk);
        chk("R8 released", 32'(fwd_valid), 0);
        chk("R8 ready again", 32'(in_ready), 1);
        chk("R8 not yet taken", 32'(loc_claim), 0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 late accept", 32'(loc_claim), 1);
        chk("R10 late cmd", 32'(out_cmd), 32'(VECS[0].cmd));

        // R3: every one-hot position
        for (int d = 0; d < 16; d++) begin
            vec_t v;
            v = '{{16'h0001, 5'(d), 3'(d % 8), 6'(d * 3), 2'b01}, 1'b1, 4'b1010, 1'b0, 3'd3};
            apply(v);
            chk("R3 sweep", fwd_addr, type0_of(v.addr));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule